// File: doc/BRIEF.md
# Wiper and comparator register controller

This block holds the live settings and shadow settings for two digital potentiometers and two voltage comparators. It also executes the instructions that a serial front end hands over. Each of the four targets owns one live register and four data registers. For a potentiometer, the live register is the wiper position. For a comparator, the live register is its analog control word.

The front end delivers one instruction byte per command, plus a data word where the command needs one. The block decodes the byte, reads, writes or moves register contents, and returns read results one cycle later. Any write into a data register starts a busy timer, which stands in for the nonvolatile programming time. While that timer runs, every command is refused.

Each comparator decision enters as an input. The block gates it onto the comparator output according to the enable, hold and power-down bits of that comparator's control word.

Top module: `potcmp_ctrl`

## Requirements
- R1: The instruction byte is split into three fields. Bits [7:4] are the opcode and bits [3:2] pick data register 0..3. Bits [1:0] pick the target: 00 is pot 0, 01 is pot 1, 10 is comparator 0, and 11 is comparator 1. The opcodes are: 9 read live, A write live, B read data register, C write data register, D data register to live, E live to data register, 1 data register to live on all targets, 8 live to data register on all targets, and 2 step wiper.
- R2: Write live (opcode A) stores the data word in the selected live register. Read live (opcode 9) returns it on rd_data_o, with rd_valid_o high for exactly the cycle after the command edge.
- R3: Write data register (opcode C) stores the data word. Read data register (opcode B) returns it with the same one-cycle timing as R2.
- R4: The two-byte transfers, opcodes D and E, copy between the selected data register and the live register of the selected target only.
- R5: The global transfers, opcodes 1 and 8, perform the same copy on all four targets at once, using the same data register index for each.
- R6: Step wiper (opcode 2) raises the wiper by one when data bit 0 is 1 and lowers it by one when that bit is 0. The wiper saturates at all-ones and at zero. On a comparator target the step has no effect.
- R7: An undefined opcode changes no register, produces no read response and does not start the busy timer.
- R8: Opcodes C, E and 8 raise busy_o from the cycle after the command. busy_o stays high for exactly BUSY_CYC cycles.
- R9: A command presented while busy_o is high is refused. No register changes and no read response is produced.
- R10: The control word bit positions are: bit 0 enable, bit 1 hold, bit 2 power-down. While enable is 0, the comparator output is 0.
- R11: With enable set and hold set, the output keeps the comparator input value sampled at the edge where hold became set.
- R12: While power-down is set, the comparator output is 0 and that comparator's analog_en_o bit is 0.
- R13: After reset, all registers are 0, busy_o is 0, rd_valid_o is 0 and the comparator outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe from the serial front end |
| cmd_instr_i | input | 8 | Instruction byte |
| cmd_data_i | input | W | Data word for write and step commands |
| busy_o | output | 1 | Programming timer running; commands are refused |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | W | Read result |
| wiper_o | output | 2*W | Live wiper positions, pot 1 in the upper half |
| cmp_in_i | input | 2 | Raw comparator decisions |
| cmp_out_o | output | 2 | Gated comparator outputs |
| analog_en_o | output | 2 | Analog section power enable per comparator |

## Verification
Register updates and read responses are registered at the command edge. The bench drives each command on a falling edge and checks rd_valid_o, rd_data_o and wiper_o on the next falling edge, which is one cycle after acceptance. The comparator gating is combinational from the control word and the input. Those checks therefore sample a short delay after the stimulus changes, or one cycle after a control word write. The busy window is measured by counting the falling edges on which busy_o is high, starting just after the writing command, and the count is compared with BUSY_CYC.

// File: rtl/potcmp_pkg.sv
package potcmp_pkg;
  localparam int unsigned N_TGT = 4;
  localparam int unsigned N_DR  = 4;

  localparam logic [3:0] OP_GD2L  = 4'h1;
  localparam logic [3:0] OP_STEP  = 4'h2;
  localparam logic [3:0] OP_GL2D  = 4'h8;
  localparam logic [3:0] OP_RDLV  = 4'h9;
  localparam logic [3:0] OP_WRLV  = 4'hA;
  localparam logic [3:0] OP_RDDR  = 4'hB;
  localparam logic [3:0] OP_WRDR  = 4'hC;
  localparam logic [3:0] OP_D2L   = 4'hD;
  localparam logic [3:0] OP_L2D   = 4'hE;

  localparam int unsigned ACR_EN   = 0;
  localparam int unsigned ACR_HOLD = 1;
  localparam int unsigned ACR_PD   = 2;

  typedef struct packed {
    logic       rd_live;
    logic       wr_live;
    logic       rd_dr;
    logic       wr_dr;
    logic       d2l;
    logic       l2d;
    logic       g_d2l;
    logic       g_l2d;
    logic       step;
    logic [1:0] sel;
    logic [1:0] tgt;
  } op_t;
endpackage

// File: rtl/potcmp_decode.sv
module potcmp_decode
  import potcmp_pkg::*;
(
  input  logic       valid_i,
  input  logic       busy_i,
  input  logic [7:0] instr_i,
  output op_t        op_o
);
  logic accept;
  assign accept = valid_i && !busy_i;

  always_comb begin
    op_o     = '0;
    op_o.sel = instr_i[3:2];
    op_o.tgt = instr_i[1:0];
    if (accept) begin
      unique case (instr_i[7:4])
        OP_RDLV: op_o.rd_live = 1'b1;
        OP_WRLV: op_o.wr_live = 1'b1;
        OP_RDDR: op_o.rd_dr   = 1'b1;
        OP_WRDR: op_o.wr_dr   = 1'b1;
        OP_D2L:  op_o.d2l     = 1'b1;
        OP_L2D:  op_o.l2d     = 1'b1;
        OP_GD2L: op_o.g_d2l   = 1'b1;
        OP_GL2D: op_o.g_l2d   = 1'b1;
        OP_STEP: op_o.step    = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/potcmp_busy.sv
module potcmp_busy #(
  parameter int unsigned BUSY_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i)            cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/potcmp_regs.sv
module potcmp_regs
  import potcmp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  op_t                         op_i,
  input  logic [W-1:0]                data_i,
  output logic [N_TGT-1:0][W-1:0]     live_o,
  output logic                        dr_write_o,
  output logic                        rd_valid_o,
  output logic [W-1:0]                rd_data_o
);
  localparam logic [W-1:0] WMAX = '1;

  logic [N_TGT-1:0][W-1:0]           live_q;
  logic [N_TGT-1:0][N_DR-1:0][W-1:0] dr_q;
  logic [W-1:0]                      cur_live, cur_dr;

  assign cur_live   = live_q[op_i.tgt];
  assign cur_dr     = dr_q[op_i.tgt][op_i.sel];
  assign dr_write_o = op_i.wr_dr | op_i.l2d | op_i.g_l2d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q     <= '0;
      dr_q       <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= op_i.rd_live | op_i.rd_dr;
      if (op_i.rd_live) rd_data_o <= cur_live;
      if (op_i.rd_dr)   rd_data_o <= cur_dr;
      if (op_i.wr_live) live_q[op_i.tgt] <= data_i;
      if (op_i.wr_dr)   dr_q[op_i.tgt][op_i.sel] <= data_i;
      if (op_i.d2l)     live_q[op_i.tgt] <= cur_dr;
      if (op_i.l2d)     dr_q[op_i.tgt][op_i.sel] <= cur_live;
      for (int t = 0; t < N_TGT; t++) begin
        if (op_i.g_d2l) live_q[t] <= dr_q[t][op_i.sel];
        if (op_i.g_l2d) dr_q[t][op_i.sel] <= live_q[t];
      end
      // stepping only applies to wipers (tgt[1]==0)
      if (op_i.step && !op_i.tgt[1]) begin
        if (data_i[0]) live_q[op_i.tgt] <= (cur_live == WMAX) ? cur_live : cur_live + 1'b1;
        else           live_q[op_i.tgt] <= (cur_live == '0)   ? cur_live : cur_live - 1'b1;
      end
    end
  end

  assign live_o = live_q;
endmodule

// File: rtl/potcmp_cmpgate.sv
module potcmp_cmpgate
  import potcmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] ctl_i,
  input  logic       cmp_i,
  output logic       cmp_o,
  output logic       analog_en_o
);
  logic en, hold, pd, raw, held_q;

  assign en   = ctl_i[ACR_EN];
  assign hold = ctl_i[ACR_HOLD];
  assign pd   = ctl_i[ACR_PD];
  assign raw  = cmp_i & ~pd;

  // track input until hold is set, then freeze
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= 1'b0;
    else if (!hold) held_q <= raw;
  end

  assign cmp_o       = en & ~pd & (hold ? held_q : cmp_i);
  assign analog_en_o = ~pd;
endmodule

// File: rtl/potcmp_ctrl.sv
module potcmp_ctrl
  import potcmp_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned BUSY_CYC = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_instr_i,
  input  logic [W-1:0]      cmd_data_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  output logic [W-1:0]      rd_data_o,
  output logic [1:0][W-1:0] wiper_o,
  input  logic [1:0]        cmp_in_i,
  output logic [1:0]        cmp_out_o,
  output logic [1:0]        analog_en_o
);
  op_t                    op;
  logic                   dr_write;
  logic [N_TGT-1:0][W-1:0] live;
  logic [1:0][W-1:0]      acr_q;

  potcmp_decode u_decode (
    .valid_i (cmd_valid_i),
    .busy_i  (busy_o),
    .instr_i (cmd_instr_i),
    .op_o    (op)
  );

  potcmp_regs #(.W(W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .data_i     (cmd_data_i),
    .live_o     (live),
    .dr_write_o (dr_write),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  potcmp_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dr_write),
    .busy_o  (busy_o)
  );

  assign wiper_o[0] = live[0];
  assign wiper_o[1] = live[1];
  assign acr_q[0]   = live[2];
  assign acr_q[1]   = live[3];

  for (genvar c = 0; c < 2; c++) begin : g_cmp
    potcmp_cmpgate u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctl_i       (acr_q[c][2:0]),
      .cmp_i       (cmp_in_i[c]),
      .cmp_o       (cmp_out_o[c]),
      .analog_en_o (analog_en_o[c])
    );
  end
endmodule

// File: rtl/potcmp_ctrl_chk.sv
module potcmp_ctrl_chk #(
  parameter int unsigned W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              busy_o,
  input logic              rd_valid_o,
  input logic [1:0][W-1:0] wiper_o,
  input logic [1:0][W-1:0] acr_q,
  input logic [1:0]        cmp_out_o,
  input logic [1:0]        analog_en_o
);
  assert_refuse_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_valid_i |=> !rd_valid_o && $stable(wiper_o) && $stable(acr_q));

  assert_read_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_valid_i) && !$past(busy_o));

  assert_busy_from_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));

  for (genvar c = 0; c < 2; c++) begin : g_chk
    assert_off_when_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acr_q[c][0] |-> !cmp_out_o[c]);

    assert_powerdown_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acr_q[c][2] |-> !cmp_out_o[c] && !analog_en_o[c]);

    assert_hold_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acr_q[c][1] && acr_q[c][0] && !acr_q[c][2] &&
      $past(acr_q[c][1]) && $past(acr_q[c][0]) && !$past(acr_q[c][2])
      |-> $stable(cmp_out_o[c]));
  end
endmodule

bind potcmp_ctrl potcmp_ctrl_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .busy_o      (busy_o),
  .rd_valid_o  (rd_valid_o),
  .wiper_o     (wiper_o),
  .acr_q       (acr_q),
  .cmp_out_o   (cmp_out_o),
  .analog_en_o (analog_en_o)
);

// File: tb/potcmp_ctrl_tb.sv
module potcmp_ctrl_tb;
  localparam int unsigned W    = 8;
  localparam int unsigned BUSY = 8;
  localparam int unsigned NV   = 22;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [7:0]        cmd_instr_i = '0;
  logic [W-1:0]      cmd_data_i = '0;
  logic              busy_o, rd_valid_o;
  logic [W-1:0]      rd_data_o;
  logic [1:0][W-1:0] wiper_o;
  logic [1:0]        cmp_in_i = '0;
  logic [1:0]        cmp_out_o, analog_en_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  potcmp_ctrl #(.W(W), .BUSY_CYC(BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
    .cmd_instr_i(cmd_instr_i), .cmd_data_i(cmd_data_i), .busy_o(busy_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .wiper_o(wiper_o),
    .cmp_in_i(cmp_in_i), .cmp_out_o(cmp_out_o), .analog_en_o(analog_en_o)
  );

  // {instr, data, expected valid, expected read data}
  localparam logic [24:0] VEC [NV] = '{
    {8'hA0, 8'h15, 1'b0, 8'h00},  // R2 write pot0
    {8'h90, 8'h00, 1'b1, 8'h15},  // R2 read pot0
    {8'hC8, 8'h2A, 1'b0, 8'h00},  // R3 write pot0 dr2
    {8'hB8, 8'h00, 1'b1, 8'h2A},  // R3 read pot0 dr2
    {8'hD8, 8'h00, 1'b0, 8'h00},  // R4 dr2 -> pot0
    {8'h90, 8'h00, 1'b1, 8'h2A},  // R4
    {8'hA1, 8'h07, 1'b0, 8'h00},  // R1 target field pot1
    {8'hE5, 8'h00, 1'b0, 8'h00},  // R4 pot1 -> dr1
    {8'hB5, 8'h00, 1'b1, 8'h07},  // R4
    {8'h21, 8'h01, 1'b0, 8'h00},  // R6 step up pot1
    {8'h91, 8'h00, 1'b1, 8'h08},  // R6
    {8'hCC, 8'h11, 1'b0, 8'h00},  // R5 setup dr3
    {8'hCD, 8'h22, 1'b0, 8'h00},
    {8'hCE, 8'h05, 1'b0, 8'h00},
    {8'hCF, 8'h01, 1'b0, 8'h00},
    {8'h1C, 8'h00, 1'b0, 8'h00},  // R5 global dr3 -> live
    {8'h90, 8'h00, 1'b1, 8'h11},
    {8'h91, 8'h00, 1'b1, 8'h22},
    {8'h92, 8'h00, 1'b1, 8'h05},
    {8'h93, 8'h00, 1'b1, 8'h01},
    {8'h00, 8'h3F, 1'b0, 8'h00},  // R7 undefined opcode
    {8'h90, 8'h00, 1'b1, 8'h11}   // R7 pot0 unchanged
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] ins, input logic [W-1:0] dat);
    @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_instr_i = ins;
    cmd_data_i  = dat;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R13 busy", busy_o, 0);
    chk("R13 rd_valid", rd_valid_o, 0);
    chk("R13 wiper", wiper_o, 0);
    rst_ni = 1'b1;
    cmp_in_i = 2'b11;
    @(negedge clk);
    chk("R13 cmp_out", cmp_out_o, 0);

    for (int i = 0; i < NV; i++) begin
      wait_idle();
      do_cmd(VEC[i][24:17], VEC[i][16:9]);
      chk($sformatf("R1 R2 R3 R4 R5 R6 R7 vec%0d valid", i), rd_valid_o, VEC[i][8]);
      if (VEC[i][8]) chk($sformatf("R1 R2 R3 R4 R5 vec%0d data", i), rd_data_o, VEC[i][7:0]);
    end
    chk("R7 no busy", busy_o, 0);
    chk("R5 wiper pins", wiper_o, {8'h22, 8'h11});

    // cmp0 = enable+powerdown, cmp1 = enable
    #1;
    chk("R12 out low", cmp_out_o[0], 0);
    chk("R12 analog off", analog_en_o, 2'b10);
    chk("R10 enabled follows", cmp_out_o[1], 1);

    do_cmd(8'hA3, 8'h03);               // R11 set hold, input 1
    cmp_in_i = 2'b01;
    repeat (3) @(negedge clk);
    chk("R11 held", cmp_out_o[1], 1);
    do_cmd(8'hA3, 8'h01);               // R11 release hold
    chk("R11 released", cmp_out_o[1], 0);
    cmp_in_i = 2'b10;
    #1;
    chk("R10 enabled", cmp_out_o[1], 1);
    do_cmd(8'hA3, 8'h00);
    chk("R10 disabled", cmp_out_o[1], 0);

    do_cmd(8'hA0, 8'hFF);               // R6 saturation
    do_cmd(8'h20, 8'h01);
    chk("R6 top", wiper_o[0], 8'hFF);
    do_cmd(8'hA0, 8'h00);
    do_cmd(8'h20, 8'h00);
    chk("R6 bottom", wiper_o[0], 8'h00);
    do_cmd(8'h23, 8'h01);
    do_cmd(8'h93, 8'h00);
    chk("R6 cmp step ignored", rd_data_o, 8'h00);

    do_cmd(8'hC0, 8'h03);               // R8 busy length
    n = 0;
    while (busy_o && n < 100) begin n++; @(negedge clk); end
    chk("R8 busy cycles", n, BUSY);

    do_cmd(8'hC0, 8'h04);               // R9 refuse while busy
    do_cmd(8'hA0, 8'h3C);
    chk("R9 wiper kept", wiper_o[0], 8'h00);
    do_cmd(8'h90, 8'h00);
    chk("R9 no read", rd_valid_o, 0);
    wait_idle();
    do_cmd(8'h90, 8'h00);
    chk("R9 read after idle", rd_data_o, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule